// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block steps a request to move a device into a new lifecycle state through a fixed, validated pipeline. When a request arrives it first waits for a clock-source acknowledgement. It then checks and advances a transition counter and has the new count written to non-volatile storage. Next it checks that the target state lies beyond the current one and obtains a hashed unlock token, which it compares against the expected hash twice in a row. Only after both comparisons agree does it write the new state. Every failing step ends in a terminal post-transition state with a sticky error flag that names the failing step.

Two independent escalation inputs override the pipeline. Either one alone sends the machine to a terminal escalate state. A scrap condition seen while idle goes straight to a terminal scrap state. The state register uses sparse codes. A value that is not one of the fifteen codes leads to an invalid state, which raises a fatal alert. Token hashing, storage programming and clock switching happen outside the block. The block sees them only as request/acknowledge pairs.

Top module: `lcx_seq`

## Requirements
- R1: `state_idx_o` reports the state as an index: Reset 0, Idle 1, ClkMux 2, CntIncr 3, CntProg 4, TransCheck 5, TokenHash 6, FlashRma 7, TokenCheck0 8, TokenCheck1 9, TransProg 10, PostTrans 11, Scrap 12, Escalate 13, Invalid 14. A register value that is no legal code reports 15. While reset is asserted the index is 0.
- R2: Reset always moves to Idle on the next clock edge, whatever the other inputs are.
- R3: In Idle, escalation has top priority, a scrap condition comes next and goes to Scrap, and a request comes last and goes to ClkMux. With none of them present the machine stays in Idle.
- R4: The forward order is ClkMux, CntIncr, CntProg, TransCheck, TokenHash, FlashRma, TokenCheck0, TokenCheck1, TransProg. ClkMux waits for `clk_ack_i`, CntProg and TransProg wait for `prog_ack_i`, TokenHash waits for `hash_ack_i`, and FlashRma lasts one cycle.
- R5: CntIncr fails to PostTrans and sets `cnt_err_o` when `cnt_i` is at least 24. Otherwise it continues to CntProg. `prog_cnt_o` always equals `cnt_i + 1`.
- R6: An acknowledge with `prog_err_i` high, in CntProg or in TransProg, goes to PostTrans and sets `prog_err_o`.
- R7: TransCheck fails to PostTrans and sets `trans_err_o` when `tgt_i <= cur_i` (unsigned).
- R8: `tok_err_o` is set and the machine goes to PostTrans in three cases: `hash_err_i` arrives with the TokenHash acknowledge, TokenCheck0 sees `hash_i != exp_hash_i`, or TokenCheck1 sees `hash_i != exp_hash_i`. TokenCheck1 lasts exactly one cycle.
- R9: An error-free acknowledge in TransProg goes to PostTrans with `done_o` high and all four error flags low.
- R10: Either `esc0_i` or `esc1_i` alone moves any state from Idle through PostTrans, or Invalid, to Escalate on the next edge.
- R11: PostTrans (without escalation), Scrap and Escalate hold until reset. Scrap ignores escalation and requests.
- R12: An illegal register value is followed by Invalid. `fatal_o` is high exactly while the machine is in Invalid.
- R13: The block raises `clk_req_o` only in ClkMux, `prog_req_o` only in CntProg and TransProg, and `hash_req_o` only in TokenHash. `prog_sel_o` is 0 for the counter write (CntProg) and 1 for the state write (TransProg).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transition request |
| scrap_i | input | 1 | Scrap condition, acted on in Idle |
| cur_i | input | TGT_W | Current lifecycle state |
| tgt_i | input | TGT_W | Requested target state |
| cnt_i | input | CNT_W | Current transition count |
| clk_ack_i | input | 1 | Clock source switched |
| prog_ack_i | input | 1 | Storage write finished |
| prog_err_i | input | 1 | Storage write failed (valid with ack) |
| hash_ack_i | input | 1 | Token hash ready |
| hash_err_i | input | 1 | Token hashing failed (valid with ack) |
| hash_i | input | HASH_W | Hashed unlock token |
| exp_hash_i | input | HASH_W | Expected token hash |
| esc0_i | input | 1 | Escalation input 0 |
| esc1_i | input | 1 | Escalation input 1 |
| clk_req_o | output | 1 | Clock switch request |
| prog_req_o | output | 1 | Storage write request |
| prog_sel_o | output | 1 | 0: counter write, 1: state write |
| prog_cnt_o | output | CNT_W | Incremented count to be written |
| hash_req_o | output | 1 | Token hash request |
| state_idx_o | output | 4 | State index (R1) |
| done_o | output | 1 | Transition completed without error |
| cnt_err_o | output | 1 | Counter exhausted |
| trans_err_o | output | 1 | Target not beyond current state |
| tok_err_o | output | 1 | Token hash failure or mismatch |
| prog_err_o | output | 1 | Storage write failure |
| fatal_o | output | 1 | Illegal state encoding detected |

## Verification
The properties assume that the state register changes only through its own clock edge. The one exception is a deliberate corruption, which they cover by tying any illegal value to an Invalid next state rather than to a later register value. They also assume that the acknowledge and error inputs are settled at each edge. The bench drives every input only at the falling edge and holds it through the next rising edge. It corrupts the register once, by forcing a non-code value between edges and then releasing it.

// File: rtl/lcx_pkg.sv
package lcx_pkg;
  localparam int ST_W = 8;

  typedef enum logic [ST_W-1:0] {
    ST_RESET    = 8'h3A,
    ST_IDLE     = 8'hC5,
    ST_CLKMUX   = 8'h59,
    ST_CNTINCR  = 8'h96,
    ST_CNTPROG  = 8'h2E,
    ST_TRCHK    = 8'hE1,
    ST_TOKHASH  = 8'h74,
    ST_RMA      = 8'h8B,
    ST_TOKCHK0  = 8'h1D,
    ST_TOKCHK1  = 8'hD2,
    ST_TRPROG   = 8'h67,
    ST_POST     = 8'hA8,
    ST_SCRAP    = 8'h4F,
    ST_ESCALATE = 8'hB0,
    ST_INVALID  = 8'h03
  } lcx_st_e;

  localparam logic [3:0] IDX_BAD = 4'd15;

  function automatic logic [3:0] st_index(input logic [ST_W-1:0] code);
    case (code)
      ST_RESET:    return 4'd0;
      ST_IDLE:     return 4'd1;
      ST_CLKMUX:   return 4'd2;
      ST_CNTINCR:  return 4'd3;
      ST_CNTPROG:  return 4'd4;
      ST_TRCHK:    return 4'd5;
      ST_TOKHASH:  return 4'd6;
      ST_RMA:      return 4'd7;
      ST_TOKCHK0:  return 4'd8;
      ST_TOKCHK1:  return 4'd9;
      ST_TRPROG:   return 4'd10;
      ST_POST:     return 4'd11;
      ST_SCRAP:    return 4'd12;
      ST_ESCALATE: return 4'd13;
      ST_INVALID:  return 4'd14;
      default:     return IDX_BAD;
    endcase
  endfunction

  function automatic logic st_legal(input logic [ST_W-1:0] code);
    return st_index(code) != IDX_BAD;
  endfunction
endpackage

// File: rtl/lcx_tok_cmp.sv
module lcx_tok_cmp #(
  parameter int HASH_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [HASH_W-1:0] hash_i,
  input  logic [HASH_W-1:0] exp_i,
  output logic              match_o
);
  localparam int LANES = HASH_W / LANE_W;

  logic [LANES-1:0] lane_eq;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (hash_i[g*LANE_W +: LANE_W] == exp_i[g*LANE_W +: LANE_W]);
  end

  assign match_o = &lane_eq;
endmodule

// File: rtl/lcx_sreg.sv
module lcx_sreg
  import lcx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  lcx_st_e         nxt_i,
  output logic [ST_W-1:0] state_o
);
  logic [ST_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= nxt_i;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lcx_next.sv
module lcx_next
  import lcx_pkg::*;
#(
  parameter int TGT_W   = 4,
  parameter int CNT_W   = 5,
  parameter int CNT_MAX = 24
) (
  input  logic [ST_W-1:0]  state_i,
  input  logic             req_i,
  input  logic             scrap_i,
  input  logic             esc_i,
  input  logic             clk_ack_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [TGT_W-1:0] cur_i,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic             prog_ack_i,
  input  logic             prog_err_i,
  input  logic             hash_ack_i,
  input  logic             hash_err_i,
  input  logic             tok_match_i,
  output lcx_st_e          nxt_o,
  output logic             fail_cnt_o,
  output logic             fail_trans_o,
  output logic             fail_tok_o,
  output logic             fail_prog_o
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(CNT_MAX);

  function automatic logic cnt_full(input logic [CNT_W-1:0] c);
    return c >= CNT_LIM;
  endfunction

  function automatic logic tgt_ok(input logic [TGT_W-1:0] cur, input logic [TGT_W-1:0] tgt);
    return tgt > cur;
  endfunction

  logic may_esc;
  assign may_esc = st_legal(state_i) && (state_i != ST_RESET) &&
                   (state_i != ST_SCRAP) && (state_i != ST_ESCALATE);

  always_comb begin
    nxt_o        = ST_INVALID;
    fail_cnt_o   = 1'b0;
    fail_trans_o = 1'b0;
    fail_tok_o   = 1'b0;
    fail_prog_o  = 1'b0;
    case (state_i)
      ST_RESET:   nxt_o = ST_IDLE;
      ST_IDLE: begin
        if (scrap_i)    nxt_o = ST_SCRAP;
        else if (req_i) nxt_o = ST_CLKMUX;
        else            nxt_o = ST_IDLE;
      end
      ST_CLKMUX:  nxt_o = clk_ack_i ? ST_CNTINCR : ST_CLKMUX;
      ST_CNTINCR: begin
        if (cnt_full(cnt_i)) begin
          nxt_o      = ST_POST;
          fail_cnt_o = 1'b1;
        end else begin
          nxt_o = ST_CNTPROG;
        end
      end
      ST_CNTPROG: begin
        if (!prog_ack_i) nxt_o = ST_CNTPROG;
        else if (prog_err_i) begin
          nxt_o       = ST_POST;
          fail_prog_o = 1'b1;
        end else nxt_o = ST_TRCHK;
      end
      ST_TRCHK: begin
        if (tgt_ok(cur_i, tgt_i)) nxt_o = ST_TOKHASH;
        else begin
          nxt_o        = ST_POST;
          fail_trans_o = 1'b1;
        end
      end
      ST_TOKHASH: begin
        if (!hash_ack_i) nxt_o = ST_TOKHASH;
        else if (hash_err_i) begin
          nxt_o      = ST_POST;
          fail_tok_o = 1'b1;
        end else nxt_o = ST_RMA;
      end
      ST_RMA:     nxt_o = ST_TOKCHK0;
      ST_TOKCHK0: begin
        if (tok_match_i) nxt_o = ST_TOKCHK1;
        else begin
          nxt_o      = ST_POST;
          fail_tok_o = 1'b1;
        end
      end
      ST_TOKCHK1: begin
        if (tok_match_i) nxt_o = ST_TRPROG;
        else begin
          nxt_o      = ST_POST;
          fail_tok_o = 1'b1;
        end
      end
      ST_TRPROG: begin
        if (!prog_ack_i) nxt_o = ST_TRPROG;
        else begin
          nxt_o       = ST_POST;
          fail_prog_o = prog_err_i;
        end
      end
      ST_POST:     nxt_o = ST_POST;
      ST_SCRAP:    nxt_o = ST_SCRAP;
      ST_ESCALATE: nxt_o = ST_ESCALATE;
      ST_INVALID:  nxt_o = ST_INVALID;
      default:     nxt_o = ST_INVALID;
    endcase
    if (esc_i && may_esc) begin
      nxt_o        = ST_ESCALATE;
      fail_cnt_o   = 1'b0;
      fail_trans_o = 1'b0;
      fail_tok_o   = 1'b0;
      fail_prog_o  = 1'b0;
    end
  end
endmodule

// File: rtl/lcx_seq.sv
module lcx_seq
  import lcx_pkg::*;
#(
  parameter int TGT_W   = 4,
  parameter int CNT_W   = 5,
  parameter int CNT_MAX = 24,
  parameter int HASH_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              scrap_i,
  input  logic [TGT_W-1:0]  cur_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              clk_ack_i,
  input  logic              prog_ack_i,
  input  logic              prog_err_i,
  input  logic              hash_ack_i,
  input  logic              hash_err_i,
  input  logic [HASH_W-1:0] hash_i,
  input  logic [HASH_W-1:0] exp_hash_i,
  input  logic              esc0_i,
  input  logic              esc1_i,
  output logic              clk_req_o,
  output logic              prog_req_o,
  output logic              prog_sel_o,
  output logic [CNT_W-1:0]  prog_cnt_o,
  output logic              hash_req_o,
  output logic [3:0]        state_idx_o,
  output logic              done_o,
  output logic              cnt_err_o,
  output logic              trans_err_o,
  output logic              tok_err_o,
  output logic              prog_err_o,
  output logic              fatal_o
);
  logic [ST_W-1:0] state_q;
  lcx_st_e         nxt;
  logic            esc_w;
  logic            tok_match_w;
  logic            fail_cnt_w, fail_trans_w, fail_tok_w, fail_prog_w;
  logic            legal_w, nxt_invalid_w;
  logic [3:0]      err_q; // {prog, tok, trans, cnt}

  assign esc_w = esc0_i | esc1_i;

  lcx_tok_cmp #(.HASH_W(HASH_W)) u_cmp (
    .hash_i  (hash_i),
    .exp_i   (exp_hash_i),
    .match_o (tok_match_w)
  );

  lcx_next #(.TGT_W(TGT_W), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_next (
    .state_i      (state_q),
    .req_i        (req_i),
    .scrap_i      (scrap_i),
    .esc_i        (esc_w),
    .clk_ack_i    (clk_ack_i),
    .cnt_i        (cnt_i),
    .cur_i        (cur_i),
    .tgt_i        (tgt_i),
    .prog_ack_i   (prog_ack_i),
    .prog_err_i   (prog_err_i),
    .hash_ack_i   (hash_ack_i),
    .hash_err_i   (hash_err_i),
    .tok_match_i  (tok_match_w),
    .nxt_o        (nxt),
    .fail_cnt_o   (fail_cnt_w),
    .fail_trans_o (fail_trans_w),
    .fail_tok_o   (fail_tok_w),
    .fail_prog_o  (fail_prog_w)
  );

  lcx_sreg u_sreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nxt_i   (nxt),
    .state_o (state_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= err_q | {fail_prog_w, fail_tok_w, fail_trans_w, fail_cnt_w};
  end

  assign legal_w       = st_legal(state_q);
  assign nxt_invalid_w = (nxt == ST_INVALID);

  assign state_idx_o = st_index(state_q);
  assign clk_req_o   = (state_q == ST_CLKMUX);
  assign prog_req_o  = (state_q == ST_CNTPROG) || (state_q == ST_TRPROG);
  assign prog_sel_o  = (state_q == ST_TRPROG);
  assign prog_cnt_o  = cnt_i + CNT_W'(1);
  assign hash_req_o  = (state_q == ST_TOKHASH);
  assign cnt_err_o   = err_q[0];
  assign trans_err_o = err_q[1];
  assign tok_err_o   = err_q[2];
  assign prog_err_o  = err_q[3];
  assign done_o      = (state_q == ST_POST) && (err_q == '0);
  assign fatal_o     = (state_q == ST_INVALID);
endmodule

// File: rtl/lcx_seq_chk.sv
module lcx_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       esc0_i,
  input logic       esc1_i,
  input logic [3:0] state_idx_o,
  input logic       fatal_o,
  input logic       clk_req_o,
  input logic       prog_req_o,
  input logic       hash_req_o,
  input logic       cnt_err_o,
  input logic       fail_cnt_w,
  input logic       legal_w,
  input logic       nxt_invalid_w
);
  logic esc;
  assign esc = esc0_i | esc1_i;

  a_r2_reset_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_idx_o == 4'd0 |=> state_idx_o == 4'd1);

  a_r5_cnt_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_cnt_w |=> (cnt_err_o && state_idx_o == 4'd11));

  a_r8_tc1_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_idx_o == 4'd9 |=> state_idx_o != 4'd9);

  a_r10_escalate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc && ((state_idx_o >= 4'd1 && state_idx_o <= 4'd11) || state_idx_o == 4'd14))
    |=> state_idx_o == 4'd13);

  a_r11_scrap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_idx_o == 4'd12 |=> state_idx_o == 4'd12);

  a_r11_esc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_idx_o == 4'd13 |=> state_idx_o == 4'd13);

  a_r11_post_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_idx_o == 4'd11 && !esc) |=> state_idx_o == 4'd11);

  a_r12_illegal_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal_w |-> nxt_invalid_w);

  a_r12_fatal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fatal_o && !esc) |=> fatal_o);

  a_r13_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clk_req_o, prog_req_o, hash_req_o}));
endmodule

bind lcx_seq lcx_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .esc0_i        (esc0_i),
  .esc1_i        (esc1_i),
  .state_idx_o   (state_idx_o),
  .fatal_o       (fatal_o),
  .clk_req_o     (clk_req_o),
  .prog_req_o    (prog_req_o),
  .hash_req_o    (hash_req_o),
  .cnt_err_o     (cnt_err_o),
  .fail_cnt_w    (fail_cnt_w),
  .legal_w       (legal_w),
  .nxt_invalid_w (nxt_invalid_w)
);

// File: tb/tb_lcx_seq.sv
module tb_lcx_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i, scrap_i, clk_ack_i, prog_ack_i, prog_err_i;
  logic        hash_ack_i, hash_err_i, esc0_i, esc1_i;
  logic [3:0]  cur_i, tgt_i;
  logic [4:0]  cnt_i;
  logic [31:0] hash_i, exp_hash_i;
  logic        clk_req_o, prog_req_o, prog_sel_o, hash_req_o;
  logic [4:0]  prog_cnt_o;
  logic [3:0]  state_idx_o;
  logic        done_o, cnt_err_o, trans_err_o, tok_err_o, prog_err_o, fatal_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lcx_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .scrap_i(scrap_i),
    .cur_i(cur_i), .tgt_i(tgt_i), .cnt_i(cnt_i), .clk_ack_i(clk_ack_i),
    .prog_ack_i(prog_ack_i), .prog_err_i(prog_err_i), .hash_ack_i(hash_ack_i),
    .hash_err_i(hash_err_i), .hash_i(hash_i), .exp_hash_i(exp_hash_i),
    .esc0_i(esc0_i), .esc1_i(esc1_i), .clk_req_o(clk_req_o),
    .prog_req_o(prog_req_o), .prog_sel_o(prog_sel_o), .prog_cnt_o(prog_cnt_o),
    .hash_req_o(hash_req_o), .state_idx_o(state_idx_o), .done_o(done_o),
    .cnt_err_o(cnt_err_o), .trans_err_o(trans_err_o), .tok_err_o(tok_err_o),
    .prog_err_o(prog_err_o), .fatal_o(fatal_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic defaults();
    req_i = 0; scrap_i = 0; cur_i = 4'd1; tgt_i = 4'd5; cnt_i = 5'd3;
    clk_ack_i = 1; prog_ack_i = 1; prog_err_i = 0; hash_ack_i = 1; hash_err_i = 0;
    hash_i = 32'hA5A5_0F0F; exp_hash_i = 32'hA5A5_0F0F; esc0_i = 0; esc1_i = 0;
  endtask

  // leaves the machine in Idle
  task automatic do_reset();
    rst_ni = 1'b0;
    defaults();
    repeat (2) @(negedge clk);
    check("R1 index in reset", state_idx_o, 0);
    rst_ni = 1'b1;
    step();
    check("R2 reset to idle", state_idx_o, 1);
  endtask

  task automatic walk_to(input int t);
    req_i = 1;
    for (int k = 0; k < 20 && state_idx_o != 4'(t); k++) step();
    check("R4 reach state", state_idx_o, t);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 no flag after reset", {cnt_err_o, trans_err_o, tok_err_o, prog_err_o}, 0);
    check("R12 fatal low", fatal_o, 0);
    // Reset ignores escalation; Idle then escalates
    rst_ni = 0; esc1_i = 1;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    step();
    check("R2 reset ignores esc", state_idx_o, 1);
    step();
    check("R10 idle esc1", state_idx_o, 13);
  endtask

  task automatic t_happy();
    do_reset();
    req_i = 1;
    for (int s = 2; s <= 11; s++) begin
      step();
      check("R4 forward order", state_idx_o, s);
      check("R13 clk_req", clk_req_o, int'(s == 2));
      check("R13 prog_req", prog_req_o, int'(s == 4 || s == 10));
      check("R13 hash_req", hash_req_o, int'(s == 6));
      if (s == 4) begin
        check("R13 counter select", prog_sel_o, 0);
        check("R5 incremented count", prog_cnt_o, 4);
      end
      if (s == 10) check("R13 state select", prog_sel_o, 1);
    end
    check("R9 done", done_o, 1);
    check("R9 flags clear", {cnt_err_o, trans_err_o, tok_err_o, prog_err_o}, 0);
    step(); step();
    check("R11 post holds", state_idx_o, 11);
  endtask

  task automatic t_waits();
    do_reset();
    clk_ack_i = 0; prog_ack_i = 0; hash_ack_i = 0;
    req_i = 1;
    step(); check("R4 clkmux", state_idx_o, 2);
    step(); check("R4 clkmux waits", state_idx_o, 2);
    clk_ack_i = 1;
    step(); check("R4 cntincr", state_idx_o, 3);
    step(); check("R4 cntprog", state_idx_o, 4);
    step(); check("R4 cntprog waits", state_idx_o, 4);
    prog_ack_i = 1;
    step(); check("R4 transcheck", state_idx_o, 5);
    step(); check("R4 tokenhash", state_idx_o, 6);
    step(); check("R4 tokenhash waits", state_idx_o, 6);
    hash_ack_i = 1;
    step(); check("R4 flashrma", state_idx_o, 7);
    step(); check("R4 flashrma one cycle", state_idx_o, 8);
  endtask

  task automatic t_counter();
    do_reset(); cnt_i = 5'd24;
    walk_to(3);
    step();
    check("R5 full counter to post", state_idx_o, 11);
    check("R5 cnt_err", cnt_err_o, 1);
    check("R9 no done on error", done_o, 0);
    do_reset(); cnt_i = 5'd23;
    walk_to(3);
    step();
    check("R5 count 23 proceeds", state_idx_o, 4);
    check("R5 count 23 write value", prog_cnt_o, 24);
  endtask

  task automatic t_prog_err();
    do_reset();
    walk_to(4);
    prog_err_i = 1; step();
    check("R6 cntprog error", state_idx_o, 11);
    check("R6 prog_err flag", prog_err_o, 1);
    do_reset();
    walk_to(10);
    prog_err_i = 1; step();
    check("R6 transprog error", state_idx_o, 11);
    check("R6 prog_err flag transprog", prog_err_o, 1);
  endtask

  task automatic t_trans();
    do_reset(); tgt_i = 4'd1;
    walk_to(5); step();
    check("R7 equal target fails", state_idx_o, 11);
    check("R7 trans_err", trans_err_o, 1);
    do_reset(); cur_i = 4'd6; tgt_i = 4'd7;
    walk_to(5); step();
    check("R7 higher target passes", state_idx_o, 6);
  endtask

  task automatic t_token();
    do_reset();
    walk_to(6); hash_err_i = 1; step();
    check("R8 hash error", state_idx_o, 11);
    check("R8 tok_err hash", tok_err_o, 1);
    do_reset();
    walk_to(8); hash_i = 32'hA5A5_0F0E; step();
    check("R8 tc0 mismatch", state_idx_o, 11);
    check("R8 tok_err tc0", tok_err_o, 1);
    do_reset();
    walk_to(9); hash_i = 32'h25A5_0F0F; step();
    check("R8 tc1 mismatch", state_idx_o, 11);
    check("R8 tok_err tc1", tok_err_o, 1);
    do_reset();
    walk_to(9); step();
    check("R8 tc1 leaves after one cycle", state_idx_o, 10);
  endtask

  task automatic t_escalate();
    for (int s = 1; s <= 11; s++) begin
      do_reset();
      walk_to(s);
      if (s % 2 == 1) esc0_i = 1; else esc1_i = 1;
      step();
      check("R10 escalate from state", state_idx_o, 13);
      esc0_i = 0; esc1_i = 0; req_i = 0;
      step();
      check("R11 escalate holds", state_idx_o, 13);
    end
  endtask

  task automatic t_idle_routes();
    do_reset();
    step(); check("R3 idle without input", state_idx_o, 1);
    scrap_i = 1; req_i = 1; step();
    check("R3 scrap beats request", state_idx_o, 12);
    scrap_i = 0; esc0_i = 1; step();
    check("R11 scrap ignores esc", state_idx_o, 12);
    esc0_i = 0; step();
    check("R11 scrap ignores req", state_idx_o, 12);
    do_reset();
    scrap_i = 1; esc1_i = 1; step();
    check("R3 esc beats scrap", state_idx_o, 13);
  endtask

  task automatic t_illegal();
    do_reset();
    @(negedge clk);
    force dut.u_sreg.state_q = 8'h00;
    @(posedge clk); @(negedge clk);
    check("R1 illegal index", state_idx_o, 15);
    release dut.u_sreg.state_q;
    step();
    check("R12 invalid reached", state_idx_o, 14);
    check("R12 fatal high", fatal_o, 1);
    step();
    check("R12 invalid holds", state_idx_o, 14);
    esc0_i = 1; step();
    check("R10 invalid escalates", state_idx_o, 13);
    check("R12 fatal low outside invalid", fatal_o, 0);
  endtask

  initial begin
    defaults();
    t_reset();
    t_happy();
    t_waits();
    t_counter();
    t_prog_err();
    t_trans();
    t_token();
    t_escalate();
    t_idle_routes();
    t_illegal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule